// File: doc/BRIEF.md
# Set/Reset Dual-Output PWM Timer

This block is a PWM timer with one up-counter and two outputs. Each output has two compare registers. A match on one register drives the output to its active level, and a match on the other drives it back to inactive. The first register of output A also sets the common period. A period match returns the counter to zero on the next count tick. Because each edge of each output has its own compare value, the counter only ever counts up.

Software controls the timer through a few strobes:
- a start strobe with a run value, to start or stop counting;
- a counter-load strobe;
- a compare-write strobe with an index.

A mode input makes the counter halt by itself on the period match. A buffered-update input routes compare writes to shadow copies, which move into the live registers only on a period match. An external cutoff input forces both outputs inactive at once and latches a flag, which software must clear. The timer pulses a one-cycle strobe for each compare match and for counter overflow. These strobes feed an interrupt controller.

Top module: `sr_pwm_timer`

## Requirements
- R1: After reset the counter is 0, `running` is 0, both outputs sit at their inactive level, and all match, overflow and cutoff indications are 0.
- R2: A tick is `tick`=1 while `running`=1 and `cnt_wr`=0. Each tick advances the counter by one. A tick with the counter equal to the period value (compare index 0) loads 0 instead, so the period is period+1 ticks. Without a tick the counter holds.
- R3: Output A internal state goes active after a tick at the value of compare index 1, and inactive after a tick at the value of compare index 0. This gives (index0 − index1) active ticks. When both match on the same tick, inactive wins.
- R4: Output B internal state goes active after a tick at the value of compare index 3, and inactive after a tick at the value of compare index 2. This gives (index2 − index3) active ticks.
- R5: `start_wr`=1 loads `running` from `start_val` at the next edge. While `running`=0 the counter and both outputs hold their values.
- R6: With `stop_at_period`=1, a tick at the period value clears `running` and the counter. Both outputs keep the levels that this match produced. A simultaneous `start_wr` takes priority.
- R7: `match_pulse` bit i is high for the one cycle after a tick on which the counter equalled compare index i. The indices are 0 = A inactive/period, 1 = A active, 2 = B inactive, 3 = B active.
- R8: A tick with the counter all ones that is not a period match wraps the counter to 0 and raises `ovf_pulse` for one cycle.
- R9: `cnt_wr`=1 loads `cnt_wdata` into the counter at the next edge. It overrides any tick, and no match or overflow event occurs in that cycle.
- R10: `act_hi` bit 0 (output A) and bit 1 (output B) select the active level: 1 means active-high and 0 means active-low.
- R11: `cutoff_in`=1 drives both outputs to their inactive level in the same cycle and sets `cutoff_flag` at the next edge. The outputs stay inactive until `cutoff_clr`=1 clears the flag while `cutoff_in`=0. After that they show the internal state again.
- R12: With `buf_en`=0 a compare write takes effect at the next edge. With `buf_en`=1 it goes to the shadow only, and all four shadows are copied into the live registers on the next period-match tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable |
| start_wr | input | 1 | Run-control write strobe |
| start_val | input | 1 | Run value written by `start_wr` |
| stop_at_period | input | 1 | Halt counting on period match |
| buf_en | input | 1 | Route compare writes through shadows |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_idx | input | 2 | Compare register index (0..3) |
| cmp_wdata | input | CW | Compare write data |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CW | Counter load value |
| act_hi | input | 2 | Active level per output |
| cutoff_in | input | 1 | Forced cutoff request |
| cutoff_clr | input | 1 | Clear latched cutoff flag |
| cnt_rd | output | CW | Current counter value |
| running | output | 1 | Counter enabled |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| match_pulse | output | 4 | Per-register match strobe |
| ovf_pulse | output | 1 | Overflow strobe |
| cutoff_flag | output | 1 | Latched cutoff indication |

## Verification
The bench checks several corner cases:
- **Period wrap.** A counter that wrapped one tick late or early would stretch or shrink every period and shift both duty cycles.
- **Tie between an output's two compare values.** A design that let the active match win would leave output A stuck active.
- **Auto-stop.** A design that cleared the outputs on auto-stop, or kept counting, would be caught there.
- **Buffered period change mid-period.** This catches a design that applied shadow values at once and produced a mixed period.
- **Cutoff release.** A design that released the outputs when the cutoff input fell, instead of on the flag clear, would show active pulses during the hold window.
- **Counter load placed above the period.** This drives the counter into overflow, and a design that skipped the overflow strobe or compared against a stale value would diverge.

// File: rtl/srpwm_pkg.sv
package srpwm_pkg;

   localparam int NCMP = 4;

   typedef enum logic [1:0] {
      CMP_A_OFF = 2'd0,
      CMP_A_ON  = 2'd1,
      CMP_B_OFF = 2'd2,
      CMP_B_ON  = 2'd3
   } cmp_sel_e;

endpackage

// File: rtl/srpwm_counter.sv
module srpwm_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          per_hit,
   input  logic          cnt_wr,
   input  logic [CW-1:0] cnt_wdata,
   input  logic          start_wr,
   input  logic          start_val,
   input  logic          stop_at_period,
   output logic          cnt_ev,
   output logic [CW-1:0] cnt_q,
   output logic          run_q,
   output logic          ovf_q
);

   localparam logic [CW-1:0] ALL_ONES = '1;

   assign cnt_ev = tick & run_q & ~cnt_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         if (cnt_wr) begin
            cnt_q <= cnt_wdata;
         end else if (cnt_ev) begin
            if (per_hit) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == ALL_ONES) ovf_q <= 1'b1;
            end
         end
         if (start_wr)
            run_q <= start_val;
         else if (cnt_ev && per_hit && stop_at_period)
            run_q <= 1'b0;
      end
   end

endmodule

// File: rtl/srpwm_cmp_bank.sv
module srpwm_cmp_bank #(
   parameter int CW   = 16,
   parameter int NREG = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [$clog2(NREG)-1:0]   idx,
   input  logic [CW-1:0]             wdata,
   input  logic                      buf_en,
   input  logic [CW-1:0]             cnt,
   input  logic                      cnt_ev,
   output logic [NREG-1:0][CW-1:0]   live,
   output logic [NREG-1:0]           hit_ev,
   output logic [NREG-1:0]           match_q
);

   localparam int IW = $clog2(NREG);

   logic [NREG-1:0][CW-1:0] shadow;
   logic                    reload;

   assign reload = buf_en & hit_ev[0];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic sel;
      assign sel       = we && (idx == IW'(i));
      assign hit_ev[i] = cnt_ev && (cnt == live[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow[i] <= '0;
            live[i]   <= '0;
         end else begin
            if (sel) shadow[i] <= wdata;
            if (reload)
               live[i] <= shadow[i];
            else if (sel && !buf_en)
               live[i] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= '0;
      else        match_q <= hit_ev;
   end

endmodule

// File: rtl/srpwm_chan.sv
module srpwm_chan #(
   parameter bit COMB_CUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_ev,
   input  logic off_ev,
   input  logic act_hi,
   input  logic cut,
   output logic pin
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= 1'b0;
      else if (off_ev) lvl_q <= 1'b0;
      else if (on_ev)  lvl_q <= 1'b1;
   end

   if (COMB_CUT) begin : g_comb
      assign pin = cut ? ~act_hi : ~(lvl_q ^ act_hi);
   end else begin : g_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= cut ? ~act_hi : ~(lvl_q ^ act_hi);
      end
      assign pin = pin_q;
   end

endmodule

// File: rtl/sr_pwm_timer.sv
module sr_pwm_timer
   import srpwm_pkg::*;
#(
   parameter int CW          = 16,
   parameter bit CUTOFF_COMB = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start_wr,
   input  logic          start_val,
   input  logic          stop_at_period,
   input  logic          buf_en,
   input  logic          cmp_we,
   input  logic [1:0]    cmp_idx,
   input  logic [CW-1:0] cmp_wdata,
   input  logic          cnt_wr,
   input  logic [CW-1:0] cnt_wdata,
   input  logic [1:0]    act_hi,
   input  logic          cutoff_in,
   input  logic          cutoff_clr,
   output logic [CW-1:0] cnt_rd,
   output logic          running,
   output logic          pwm_a,
   output logic          pwm_b,
   output logic [3:0]    match_pulse,
   output logic          ovf_pulse,
   output logic          cutoff_flag
);

   localparam int NCH = NCMP / 2;

   if (CW < 4 || CW > 32) begin : g_bad_cw
      $error("sr_pwm_timer: CW must lie in 4..32");
   end
   if (NCMP != 4) begin : g_bad_ncmp
      $error("sr_pwm_timer: four compare registers expected");
   end

   logic                    cnt_ev;
   logic [NCMP-1:0][CW-1:0] act_vals;
   logic [NCMP-1:0]         hit_ev;
   logic [CW-1:0]           per_val;
   logic                    cut_q;
   logic                    cut_any;
   logic [NCH-1:0]          pins;

   assign per_val = act_vals[CMP_A_OFF];

   srpwm_counter #(.CW(CW)) u_cnt (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick           (tick),
      .per_hit        (hit_ev[CMP_A_OFF]),
      .cnt_wr         (cnt_wr),
      .cnt_wdata      (cnt_wdata),
      .start_wr       (start_wr),
      .start_val      (start_val),
      .stop_at_period (stop_at_period),
      .cnt_ev         (cnt_ev),
      .cnt_q          (cnt_rd),
      .run_q          (running),
      .ovf_q          (ovf_pulse)
   );

   srpwm_cmp_bank #(.CW(CW), .NREG(NCMP)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cmp_we),
      .idx     (cmp_idx),
      .wdata   (cmp_wdata),
      .buf_en  (buf_en),
      .cnt     (cnt_rd),
      .cnt_ev  (cnt_ev),
      .live    (act_vals),
      .hit_ev  (hit_ev),
      .match_q (match_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cut_q <= 1'b0;
      else if (cutoff_in)  cut_q <= 1'b1;
      else if (cutoff_clr) cut_q <= 1'b0;
   end

   assign cut_any     = cutoff_in | cut_q;
   assign cutoff_flag = cut_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      srpwm_chan #(.COMB_CUT(CUTOFF_COMB)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .on_ev  (hit_ev[2*c+1]),
         .off_ev (hit_ev[2*c]),
         .act_hi (act_hi[c]),
         .cut    (cut_any),
         .pin    (pins[c])
      );
   end

   assign pwm_a = pins[0];
   assign pwm_b = pins[1];

endmodule

// File: rtl/srpwm_checker.sv
module srpwm_checker #(
   parameter int CW          = 16,
   parameter bit CUTOFF_COMB = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cnt_ev,
   input logic [CW-1:0] per_val,
   input logic [CW-1:0] cnt_rd,
   input logic          running,
   input logic          stop_at_period,
   input logic          start_wr,
   input logic          cnt_wr,
   input logic [CW-1:0] cnt_wdata,
   input logic          ovf_pulse,
   input logic          cutoff_in,
   input logic          cutoff_flag,
   input logic [1:0]    act_hi,
   input logic          pwm_a,
   input logic          pwm_b
);

   AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ev && cnt_rd == per_val) |=> (cnt_rd == '0)); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !cnt_wr) |=> $stable(cnt_rd)); // R5

   AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ev && cnt_rd == per_val && stop_at_period && !start_wr) |=> !running); // R6

   AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (cnt_rd == '0)); // R8

   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_rd == $past(cnt_wdata))); // R9

   AST_CUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cutoff_in |=> cutoff_flag); // R11

   if (CUTOFF_COMB) begin : g_cut_now
      AST_CUT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
         cutoff_in |-> (pwm_a == !act_hi[0] && pwm_b == !act_hi[1])); // R11
   end

endmodule

bind sr_pwm_timer srpwm_checker #(.CW(CW), .CUTOFF_COMB(CUTOFF_COMB)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cnt_ev         (cnt_ev),
   .per_val        (per_val),
   .cnt_rd         (cnt_rd),
   .running        (running),
   .stop_at_period (stop_at_period),
   .start_wr       (start_wr),
   .cnt_wr         (cnt_wr),
   .cnt_wdata      (cnt_wdata),
   .ovf_pulse      (ovf_pulse),
   .cutoff_in      (cutoff_in),
   .cutoff_flag    (cutoff_flag),
   .act_hi         (act_hi),
   .pwm_a          (pwm_a),
   .pwm_b          (pwm_b)
);

// File: tb/tb_sr_pwm_timer.sv
module tb_sr_pwm_timer;

   typedef struct packed {
      logic [15:0] cnt;
      logic        run;
      logic        a;
      logic        b;
      logic [3:0]  mp;
      logic        ovf;
      logic        cut;
   } obs_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 0, start_wr = 0, start_val = 0, stop_at_period = 0;
   logic        buf_en = 0, cmp_we = 0, cnt_wr = 0, cutoff_in = 0, cutoff_clr = 0;
   logic [1:0]  cmp_idx = 0;
   logic [15:0] cmp_wdata = 0, cnt_wdata = 0;
   logic [1:0]  act_hi = 2'b11;
   logic [15:0] cnt_rd;
   logic        running, pwm_a, pwm_b, ovf_pulse, cutoff_flag;
   logic [3:0]  match_pulse;

   always #2 clk = ~clk;

   sr_pwm_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_wr(start_wr),
      .start_val(start_val), .stop_at_period(stop_at_period), .buf_en(buf_en),
      .cmp_we(cmp_we), .cmp_idx(cmp_idx), .cmp_wdata(cmp_wdata),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .act_hi(act_hi),
      .cutoff_in(cutoff_in), .cutoff_clr(cutoff_clr), .cnt_rd(cnt_rd),
      .running(running), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .match_pulse(match_pulse), .ovf_pulse(ovf_pulse), .cutoff_flag(cutoff_flag)
   );

   obs_t  exp_q[$];
   string tag_q[$];
   int    n_vec = 0, n_bad = 0;
   bit    done = 0;

   logic [15:0] m_cnt = 0;
   logic        m_run = 0, m_cut = 0;
   logic [1:0]  m_lvl = 0;
   logic [15:0] m_act [4] = '{default: 16'h0};
   logic [15:0] m_sh  [4] = '{default: 16'h0};

   task automatic step(input string tag);
      logic       ev, ovf;
      logic [3:0] e;
      obs_t       x;
      ev = tick && m_run && !cnt_wr;
      for (int i = 0; i < 4; i++) e[i] = ev && (m_cnt == m_act[i]);
      ovf = ev && !e[0] && (m_cnt == 16'hFFFF);
      if (cnt_wr)  m_cnt = cnt_wdata;
      else if (ev) m_cnt = e[0] ? 16'h0 : m_cnt + 16'h1;
      if (start_wr) m_run = start_val;
      else if (e[0] && stop_at_period) m_run = 1'b0;
      for (int c = 0; c < 2; c++) begin
         if (e[2*c])        m_lvl[c] = 1'b0;
         else if (e[2*c+1]) m_lvl[c] = 1'b1;
      end
      if (buf_en && e[0]) for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
      if (cmp_we) begin
         m_sh[cmp_idx] = cmp_wdata;
         if (!buf_en) m_act[cmp_idx] = cmp_wdata;
      end
      if (cutoff_in)       m_cut = 1'b1;
      else if (cutoff_clr) m_cut = 1'b0;
      x.cnt = m_cnt;
      x.run = m_run;
      x.a   = (cutoff_in || m_cut) ? !act_hi[0] : (m_lvl[0] ? act_hi[0] : !act_hi[0]);
      x.b   = (cutoff_in || m_cut) ? !act_hi[1] : (m_lvl[1] ? act_hi[1] : !act_hi[1]);
      x.mp  = e;
      x.ovf = ovf;
      x.cut = m_cut;
      exp_q.push_back(x);
      tag_q.push_back(tag);
      @(posedge clk);
      #2;
   endtask

   task automatic wr_cmp(input logic [1:0] i, input logic [15:0] v, input string tag);
      cmp_we = 1; cmp_idx = i; cmp_wdata = v;
      step(tag);
      cmp_we = 0;
   endtask

   task automatic ticks(input int n, input string tag);
      tick = 1;
      for (int k = 0; k < n; k++) step(tag);
      tick = 0;
   endtask

   always @(posedge clk) begin
      obs_t  e, a;
      string t;
      #1;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = '{cnt: cnt_rd, run: running, a: pwm_a, b: pwm_b, mp: match_pulse,
               ovf: ovf_pulse, cut: cutoff_flag};
         n_vec++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual cnt=%h run=%b a=%b b=%b mp=%b ovf=%b cut=%b expected cnt=%h run=%b a=%b b=%b mp=%b ovf=%b cut=%b",
                     t, a.cnt, a.run, a.a, a.b, a.mp, a.ovf, a.cut,
                     e.cnt, e.run, e.a, e.b, e.mp, e.ovf, e.cut);
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      step("R1 reset state");
      step("R1 reset state");
      // direct compare writes: period 9, A on at 3, B off at 7, B on at 1
      wr_cmp(2'd0, 16'd9, "R12 direct write");
      wr_cmp(2'd1, 16'd3, "R12 direct write");
      wr_cmp(2'd2, 16'd7, "R12 direct write");
      wr_cmp(2'd3, 16'd1, "R12 direct write");
      ticks(2, "R5 not running holds");
      start_wr = 1; start_val = 1; step("R5 start"); start_wr = 0;
      ticks(25, "R2 R3 R4 R7 continuous");
      for (int k = 0; k < 12; k++) begin
         tick = k[0];
         step("R2 sparse ticks");
      end
      tick = 0;
      start_wr = 1; start_val = 0; step("R5 software stop"); start_wr = 0;
      ticks(5, "R5 stopped holds");
      act_hi = 2'b01;
      start_wr = 1; start_val = 1; step("R10 restart"); start_wr = 0;
      ticks(14, "R10 active low on B");
      act_hi = 2'b11;
      stop_at_period = 1;
      ticks(14, "R6 halt on period");
      stop_at_period = 0;
      start_wr = 1; start_val = 1; step("R5 restart"); start_wr = 0;
      tick = 1; cnt_wr = 1; cnt_wdata = 16'd5; step("R9 load overrides tick");
      cnt_wr = 0; tick = 0;
      ticks(3, "R9 count from loaded");
      cnt_wr = 1; cnt_wdata = 16'hFFFE; step("R9 load near top"); cnt_wr = 0;
      ticks(5, "R8 overflow wrap");
      ticks(6, "R2 after wrap");
      buf_en = 1;
      wr_cmp(2'd0, 16'd5, "R12 shadow only");
      wr_cmp(2'd2, 16'd4, "R12 shadow only");
      ticks(25, "R12 buffered reload");
      buf_en = 0;
      ticks(3, "R11 before cutoff");
      cutoff_in = 1; ticks(3, "R11 cutoff forcing"); cutoff_in = 0;
      ticks(4, "R11 latched hold");
      cutoff_clr = 1; step("R11 flag clear"); cutoff_clr = 0;
      ticks(8, "R11 after release");
      wr_cmp(2'd1, 16'd5, "R3 tie setup");
      ticks(14, "R3 tie inactive wins");
      step("R7 idle end");
      repeat (2) @(posedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule